// File: doc/BRIEF.md
# Real-Time Counter with Prescaled Periodic Alarm

This block is a real-time counter peripheral driven by a slow timekeeping clock and configured over a simple read/write strobe bus on a fast bus clock. A 32-bit counter advances on prescaled ticks. Each tick comes from one of four source tick inputs, which are qualified in the timekeeping clock domain. Two cascadable prescaler stages, divide-by-512 and divide-by-32, slow the count so that it covers a longer span. The prescalers are held clear whenever counting is switched off.

A periodic alarm unit counts the same prescaled ticks. When it reaches a programmed reload value, it sets a status flag, and the interrupt enable routes that flag to an interrupt line. Software clears the flag by writing a one to it. The reload value is written in the bus domain and handed to the timekeeping domain through a toggle handshake. A busy status bit shows that the handshake is still in flight. The counter value appears directly on an output port in the timekeeping domain.

Top module: `rtc_pit`

## Requirements
- R1: After reset, the control word (byte offset 0x4), the status word (0x8) and the reload value (0x10) all read 0, rtc_count is 0 and irq is 0.
- R2: While control bit 31 (count enable) is 1, rtc_count rises by one per prescaled tick. Control bit 11 enables divide-by-512 and bit 10 enables divide-by-32. The division is 1, 32, 512 or 16384. While bit 31 is 0, source ticks have no effect.
- R3: Control bits 13:12 select which bit of src_tick feeds the prescaler. Ticks on unselected inputs are ignored, and selecting index 1 (reserved) yields no ticks at all.
- R4: A control write changes bits 13:10 only when count enable currently reads 0. Otherwise those bits keep their old value, while bits 31, 15 and 14 are written as given.
- R5: A write to the reload value sets status bit 17 (busy) from the next cycle on. Busy then returns to 0 by itself once the value has reached the timekeeping domain.
- R6: A reload value write made while busy reads 1 is ignored, and the earlier value is kept.
- R7: With control bit 15 (alarm enable) set and a reload value N greater than 0, status bit 13 (flag) sets after the Nth prescaled tick and not earlier. The alarm count then restarts from 0, so the next event follows another N ticks.
- R8: A reload value of 0 produces no alarm events.
- R9: irq is the registered AND of the flag and control bit 14 (interrupt enable).
- R10: Writing a 1 to status bit 13 clears the flag, and writing a 0 there leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Byte offset of the accessed word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Alarm interrupt |
| rtc_clk | input | 1 | Timekeeping clock, asynchronous to clk |
| rtc_rst | input | 1 | Synchronous active-high reset, timekeeping domain |
| src_tick | input | 4 | Per-source tick qualifiers, timekeeping domain |
| rtc_count | output | 32 | Free-running counter value, timekeeping domain |

## Verification
The ignored-write case is the hardest to reach. It needs a second reload write to land inside the short busy window, and that window lasts only as long as the two-clock handshake takes. The bench issues a write, reads busy back at once and then writes again before the acknowledge can return, with a timekeeping clock period chosen to keep that window open. The full cascaded division needs a long run of source ticks, so one table vector drives exactly 16384 of them and expects a single count.

// File: rtl/rtc_pit_pkg.sv
package rtc_pit_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int SRC_N  = 4;
  localparam int SEL_W  = $clog2(SRC_N);
  localparam int RSVD_SRC = 1;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_RELD = 5'h10;

  localparam int B_CNTEN  = 31;
  localparam int B_ALMEN  = 15;
  localparam int B_ALMIE  = 14;
  localparam int B_SEL_LO = 12;
  localparam int B_DIVA   = 11;
  localparam int B_DIVB   = 10;
  localparam int B_FLAG   = 13;
  localparam int B_BUSY   = 17;

  typedef struct packed {
    logic             cnten;
    logic             almen;
    logic             almie;
    logic [SEL_W-1:0] sel;
    logic             diva;
    logic             divb;
  } ctrl_t;
endpackage

// File: rtl/rtc_pit_sync.sv
module rtc_pit_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/rtc_pit_divstage.sv
module rtc_pit_divstage #(
  parameter int RATIO = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en_stage,
  input  logic tick_in,
  output logic tick_out
);
  localparam int CW = $clog2(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en_stage && tick_in) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign tick_out = en_stage ? (tick_in && (cnt == LAST)) : tick_in;
endmodule

// File: rtl/rtc_pit_timebase.sv
module rtc_pit_timebase
  import rtc_pit_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NSRC    = SRC_N,
  parameter int RSVD    = RSVD_SRC,
  parameter int RATIO_A = 512,
  parameter int RATIO_B = 32,
  parameter int STAGES  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cnten_async,
  input  logic                     diva,
  input  logic                     divb,
  input  logic [$clog2(NSRC)-1:0]  sel,
  input  logic [NSRC-1:0]          src_tick,
  output logic                     ptick,
  output logic [CNT_W-1:0]         count
);
  localparam int SW = $clog2(NSRC);
  localparam int NSTAGE = 2;

  logic cnten_s;
  logic [NSTAGE:0] chain;
  logic [NSTAGE-1:0] stage_en;

  rtc_pit_sync #(.W(1), .STAGES(STAGES)) u_en_sync (
    .clk(clk), .rst(rst), .d(cnten_async), .q(cnten_s)
  );

  assign chain[0] = cnten_s && src_tick[sel] && (sel != SW'(RSVD));
  assign stage_en = {divb, diva};

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    localparam int R = (g == 0) ? RATIO_A : RATIO_B;
    rtc_pit_divstage #(.RATIO(R)) u_div (
      .clk(clk), .rst(rst), .clr(!cnten_s), .en_stage(stage_en[g]),
      .tick_in(chain[g]), .tick_out(chain[g+1])
    );
  end

  assign ptick = chain[NSTAGE];

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (ptick) count <= count + 1'b1;
  end
endmodule

// File: rtl/rtc_pit_alarm.sv
module rtc_pit_alarm #(
  parameter int VAL_W  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             almen_async,
  input  logic             req_async,
  input  logic [VAL_W-1:0] reload_bus,
  input  logic             ptick,
  output logic             ack_tgl,
  output logic             ev_tgl
);
  logic req_s, almen_s, req_d;
  logic [VAL_W-1:0] reload, acc;
  logic upd;

  rtc_pit_sync #(.W(2), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({req_async, almen_async}), .q({req_s, almen_s})
  );

  assign upd = req_s ^ req_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d   <= 1'b0;
      ack_tgl <= 1'b0;
      ev_tgl  <= 1'b0;
      reload  <= '0;
      acc     <= '0;
    end else begin
      req_d <= req_s;
      if (upd) begin
        reload  <= reload_bus;
        acc     <= '0;
        ack_tgl <= req_s;
      end else if (!almen_s) begin
        acc <= '0;
      end else if (ptick && (reload != '0)) begin
        if (acc == reload - 1'b1) begin
          acc    <= '0;
          ev_tgl <= ~ev_tgl;
        end else begin
          acc <= acc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_pit_regs.sv
module rtc_pit_regs
  import rtc_pit_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output ctrl_t             ctl,
  output logic [DATA_W-1:0] reload,
  output logic              req_tgl,
  input  logic              ack_async,
  input  logic              ev_async,
  output logic              busy,
  output logic              flag
);
  logic ack_s, ev_s, ev_d, ev_pulse;
  logic wr_ctrl, wr_stat, wr_reld;

  rtc_pit_sync #(.W(2), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({ack_async, ev_async}), .q({ack_s, ev_s})
  );

  assign busy     = req_tgl ^ ack_s;
  assign ev_pulse = ev_s ^ ev_d;
  assign wr_ctrl  = wr_en && (addr == OFS_CTRL);
  assign wr_stat  = wr_en && (addr == OFS_STAT);
  assign wr_reld  = wr_en && (addr == OFS_RELD);

  function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
    logic [DATA_W-1:0] v;
    v = '0;
    v[B_CNTEN] = c.cnten;
    v[B_ALMEN] = c.almen;
    v[B_ALMIE] = c.almie;
    v[B_SEL_LO +: SEL_W] = c.sel;
    v[B_DIVA] = c.diva;
    v[B_DIVB] = c.divb;
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl     <= '0;
      reload  <= '0;
      req_tgl <= 1'b0;
      flag    <= 1'b0;
      ev_d    <= 1'b0;
      irq     <= 1'b0;
      rdata   <= '0;
    end else begin
      ev_d <= ev_s;
      if (wr_ctrl) begin
        ctl.cnten <= wdata[B_CNTEN];
        ctl.almen <= wdata[B_ALMEN];
        ctl.almie <= wdata[B_ALMIE];
        if (!ctl.cnten) begin
          ctl.sel  <= wdata[B_SEL_LO +: SEL_W];
          ctl.diva <= wdata[B_DIVA];
          ctl.divb <= wdata[B_DIVB];
        end
      end
      if (wr_reld && !busy) begin
        reload  <= wdata;
        req_tgl <= ~req_tgl;
      end
      if (ev_pulse) flag <= 1'b1;
      else if (wr_stat && wdata[B_FLAG]) flag <= 1'b0;
      irq <= flag && ctl.almie;
      if (rd_en) begin
        rdata <= '0;
        case (addr)
          OFS_CTRL: rdata <= pack_ctrl(ctl);
          OFS_STAT: begin
            rdata[B_BUSY] <= busy;
            rdata[B_FLAG] <= flag;
          end
          OFS_RELD: rdata <= reload;
          default:  rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtc_pit.sv
module rtc_pit
  import rtc_pit_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int RATIO_A = 512,
  parameter int RATIO_B = 32,
  parameter int STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  input  logic              rtc_clk,
  input  logic              rtc_rst,
  input  logic [SRC_N-1:0]  src_tick,
  output logic [CNT_W-1:0]  rtc_count
);
  ctrl_t             ctl;
  logic [DATA_W-1:0] reload;
  logic              req_tgl, ack_tgl, ev_tgl, busy, flag, ptick;

  rtc_pit_regs #(.STAGES(STAGES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .ctl(ctl), .reload(reload),
    .req_tgl(req_tgl), .ack_async(ack_tgl), .ev_async(ev_tgl),
    .busy(busy), .flag(flag)
  );

  rtc_pit_timebase #(
    .CNT_W(CNT_W), .NSRC(SRC_N), .RSVD(RSVD_SRC),
    .RATIO_A(RATIO_A), .RATIO_B(RATIO_B), .STAGES(STAGES)
  ) u_tb (
    .clk(rtc_clk), .rst(rtc_rst), .cnten_async(ctl.cnten),
    .diva(ctl.diva), .divb(ctl.divb), .sel(ctl.sel),
    .src_tick(src_tick), .ptick(ptick), .count(rtc_count)
  );

  rtc_pit_alarm #(.VAL_W(DATA_W), .STAGES(STAGES)) u_alarm (
    .clk(rtc_clk), .rst(rtc_rst), .almen_async(ctl.almen),
    .req_async(req_tgl), .reload_bus(reload), .ptick(ptick),
    .ack_tgl(ack_tgl), .ev_tgl(ev_tgl)
  );
endmodule

// File: rtl/rtc_pit_chk.sv
module rtc_pit_chk
  import rtc_pit_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rtc_clk,
  input logic              rtc_rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq,
  input ctrl_t             ctl,
  input logic              busy,
  input logic              flag,
  input logic [DATA_W-1:0] reload,
  input logic [CNT_W-1:0]  rtc_count
);
  logic [SEL_W+1:0] cfg;
  assign cfg = {ctl.sel, ctl.diva, ctl.divb};

  // R9: interrupt only follows an enabled flag
  assert_irq_enabled_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ctl.almie));

  // R4: divider and source fields frozen while counting
  assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    $past(ctl.cnten) |-> $stable(cfg));

  // R5: busy only rises after a reload write
  assert_busy_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_en && (addr == OFS_RELD)));

  // R6: reload value never changes while busy
  assert_reload_guard_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(reload) |-> !$past(busy));

  // R10: flag clears only through a write of one
  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(wr_en && (addr == OFS_STAT) && wdata[B_FLAG]));

  // R2: counter steps by exactly one
  assert_count_step_R2: assert property (@(posedge rtc_clk) disable iff (rtc_rst)
    !$stable(rtc_count) |-> (rtc_count == $past(rtc_count) + CNT_W'(1)));
endmodule

bind rtc_pit rtc_pit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rtc_clk(rtc_clk), .rtc_rst(rtc_rst),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .irq(irq), .ctl(ctl),
  .busy(busy), .flag(flag), .reload(reload), .rtc_count(rtc_count)
);

// File: tb/rtc_pit_bench.sv
module rtc_pit_bench;
  logic        clk = 0, rtc_clk = 0;
  logic        rst = 1, rtc_rst = 1;
  logic        wr_en = 0, rd_en = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [3:0]  src_tick = '0;
  logic [31:0] rtc_count;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam logic [4:0] A_CTRL = 5'h04, A_STAT = 5'h08, A_RELD = 5'h10;
  localparam logic [31:0] EN = 32'h8000_0000;

  // columns: diva, divb, sel, tick source, tick count, expected count delta
  localparam int unsigned VEC [6][6] = '{
    '{0, 0, 0, 0,    10, 10},
    '{0, 1, 0, 0,    64,  2},
    '{1, 0, 2, 2,  1024,  2},
    '{1, 1, 3, 3, 16384,  1},
    '{0, 0, 0, 2,    20,  0},
    '{0, 0, 1, 1,    20,  0}
  };

  always #5 clk = ~clk;
  always #18.5 rtc_clk = ~rtc_clk;

  rtc_pit u_rtc_pit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rtc_clk(rtc_clk),
    .rtc_rst(rtc_rst), .src_tick(src_tick), .rtc_count(rtc_count)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic rwait(input int n);
    repeat (n) @(negedge rtc_clk);
  endtask

  task automatic ticks(input int src, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge rtc_clk); src_tick = 4'(1 << src);
    end
    @(negedge rtc_clk); src_tick = '0;
  endtask

  task automatic wait_idle(output logic [31:0] s);
    for (int k = 0; k < 60; k++) begin
      bus_read(A_STAT, s);
      if (!s[17]) break;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, s, c0;
    repeat (4) @(negedge rtc_clk);
    @(negedge clk); rst = 0; rtc_rst = 0;

    // R1 reset state
    bus_read(A_CTRL, d); check("R1 ctrl", d, 0);
    bus_read(A_STAT, d); check("R1 status", d, 0);
    bus_read(A_RELD, d); check("R1 reload", d, 0);
    check("R1 count", rtc_count, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2 R3 table of prescaler and source vectors
    for (int i = 0; i < 6; i++) begin
      logic [31:0] cfg;
      cfg = (VEC[i][2] << 12) | (VEC[i][0] << 11) | (VEC[i][1] << 10);
      bus_write(A_CTRL, cfg);
      bus_write(A_CTRL, cfg | EN);
      rwait(4);
      c0 = rtc_count;
      ticks(int'(VEC[i][3]), int'(VEC[i][4]));
      rwait(4);
      check((i < 4) ? "R2 divide" : "R3 source", rtc_count - c0, VEC[i][5]);
      bus_write(A_CTRL, 0);
      rwait(4);
    end

    // R2 no counting while disabled
    c0 = rtc_count;
    ticks(0, 10); rwait(4);
    check("R2 disabled", rtc_count - c0, 0);

    // R4 config frozen while counting
    bus_write(A_CTRL, EN);
    bus_write(A_CTRL, EN | 32'h0000_0C00 | 32'h0000_2000);
    bus_read(A_CTRL, d); check("R4 frozen", d, EN);
    bus_write(A_CTRL, 0);
    bus_write(A_CTRL, 32'h0000_0400);
    bus_read(A_CTRL, d); check("R4 idle write", d, 32'h0000_0400);
    bus_write(A_CTRL, 0);
    rwait(4);

    // R5 R6 reload handshake
    bus_write(A_CTRL, EN | 32'h0000_C000);
    bus_write(A_RELD, 5);
    bus_read(A_STAT, s); check("R5 busy set", {31'b0, s[17]}, 1);
    bus_write(A_RELD, 9);
    wait_idle(s); check("R5 busy clear", {31'b0, s[17]}, 0);
    bus_read(A_RELD, d); check("R6 ignored", d, 5);
    rwait(4);

    // R7 R9 alarm after N ticks
    ticks(0, 4); rwait(4); repeat (10) @(negedge clk);
    bus_read(A_STAT, s); check("R7 early", {31'b0, s[13]}, 0);
    check("R9 irq low", {31'b0, irq}, 0);
    ticks(0, 1); rwait(4); repeat (10) @(negedge clk);
    bus_read(A_STAT, s); check("R7 event", {31'b0, s[13]}, 1);
    check("R9 irq high", {31'b0, irq}, 1);

    // R10 write zero has no effect
    bus_write(A_STAT, 0);
    bus_read(A_STAT, s); check("R10 zero", {31'b0, s[13]}, 1);
    // R9 enable gating
    bus_write(A_CTRL, EN | 32'h0000_8000);
    repeat (3) @(negedge clk);
    check("R9 masked", {31'b0, irq}, 0);
    bus_write(A_CTRL, EN | 32'h0000_C000);
    bus_write(A_STAT, 32'h0000_2000);
    bus_read(A_STAT, s); check("R10 clear", {31'b0, s[13]}, 0);
    repeat (3) @(negedge clk);
    check("R9 after clear", {31'b0, irq}, 0);

    // R7 restart
    ticks(0, 4); rwait(4); repeat (10) @(negedge clk);
    bus_read(A_STAT, s); check("R7 restart early", {31'b0, s[13]}, 0);
    ticks(0, 1); rwait(4); repeat (10) @(negedge clk);
    bus_read(A_STAT, s); check("R7 restart event", {31'b0, s[13]}, 1);
    bus_write(A_STAT, 32'h0000_2000);

    // R8 zero reload
    bus_write(A_RELD, 0);
    wait_idle(s);
    rwait(4);
    ticks(0, 20); rwait(4); repeat (10) @(negedge clk);
    bus_read(A_STAT, s); check("R8 no event", {31'b0, s[13]}, 0);

    finish_run();
  end
endmodule